// File: doc/BRIEF.md
# Interrupt Flag and Wake-up Controller

This block keeps the interrupt status and wake-up enable byte of a small microcontroller. It watches three event sources: an analog-to-digital conversion finishing, a supply-voltage comparator, and a bank of input port pins. When a conversion finishes, the block stores the result byte, drops the conversion-busy indication and raises the conversion flag. A fall of the supply below the comparator threshold raises the low-voltage flag. While the core sleeps, any change on the port pins relative to their value at sleep entry counts as a port event.

Software reaches the block through a small register bus with four addresses: status, mask, result, and one address that reads zero. A status read returns the status byte ANDed with the mask byte. A status write can only clear the two flags. It can never set them, and it sets the three wake enables directly. While sleep is active, an enabled source raises a registered wake request to the sleep controller. The request stays high until sleep ends.

Top module: `irq_wake_ctrl`

## Requirements
- R1: When `conv_done` is high at a clock edge, that edge loads `conv_data` into the result register (address 2), clears `conv_busy` and sets the conversion flag at status bit 5.
- R2: `conv_start` at a clock edge sets `conv_busy`. If `conv_done` is high at the same edge, `conv_busy` ends cleared.
- R3: Status bit 7 shows the supply state. The comparator input `lvd_level` passes through a two-flop synchronizer. Bit 7 reads 0 when `lvd_en` is 1 and the synchronized level is 0, and reads 1 in every other case, including whenever `lvd_en` is 0.
- R4: The low-voltage flag at status bit 6 is set at the clock edge after bit 7 goes from 1 to 0. A change of bit 7 from 0 to 1 does not set it.
- R5: A write to status (address 0) clears bit 6 or bit 5 when the written bit is 0. A written 1 leaves that flag unchanged. Written bits 7, 4 and 2 have no effect, and bits 4 and 2 always read 0.
- R6: If a hardware set and a software clear of the same flag happen at one edge, the flag ends set.
- R7: A status read returns the status byte ANDed with the mask register. The mask register is at address 1, is read and written in full, and resets to 8'hFF. Address 3 reads 8'h00.
- R8: Status bits 3 (conversion wake enable), 1 (port wake enable) and 0 (low-voltage wake enable) take the written values directly and reset to 0.
- R9: The port pins pass through a two-flop synchronizer. The edge at which `sleep` rises stores the synchronized value. After that, while `sleep` is high, any synchronized bit that differs from the stored value is a port change.
- R10: `wake_req` is a register. It goes high at the edge after one of these conditions holds with `sleep` high: conversion flag with bit 3, port change with bit 1, or low-voltage flag with bit 0. It then stays high until the edge at which `sleep` is sampled low.
- R11: A synchronous active-low reset clears the flags, the enables, the result, `conv_busy` and `wake_req`, and loads the synchronizers from their inputs so that bit 7 starts from the comparator level.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Pulse: a conversion has begun |
| conv_done | input | 1 | Pulse: a conversion has finished, result valid |
| conv_data | input | 8 | Conversion result byte |
| conv_busy | output | 1 | Conversion in progress |
| lvd_en | input | 1 | Low-voltage detection enabled |
| lvd_level | input | 1 | Asynchronous comparator output, 1 = supply above threshold |
| port_in | input | PORT_W | Asynchronous port pins |
| sleep | input | 1 | Core is in sleep or idle mode |
| wake_req | output | 1 | Wake request to the sleep controller |
| cpu_addr | input | 2 | Register address: 0 status, 1 mask, 2 result, 3 zero |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |

## Verification
A flag held in the wrong state shows up at the next status read, because the read path has no register. A flag that is wrongly set or cleared is therefore visible one edge after the event that caused it. Errors in the synchronizers and the edge detector show up as a shift in the cycle at which bit 7 or bit 6 changes, so the bench samples every cycle across those windows. A wrong snapshot or wrong wake logic shows at `wake_req` three edges after a port change, one edge after a flag is set, or one edge after sleep ends.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int SYNC_LEN = 2;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_RESULT = 2'd2;

    localparam int BIT_LVST = 7;
    localparam int BIT_LVIF = 6;
    localparam int BIT_ADIF = 5;
    localparam int BIT_ADWK = 3;
    localparam int BIT_PCWK = 1;
    localparam int BIT_LVWK = 0;

    localparam logic [DATA_W-1:0] MASK_RESET = 8'hFF;

    typedef struct packed {
        logic              lv_if;
        logic              ad_if;
        logic              ad_wk;
        logic              pc_wk;
        logic              lv_wk;
        logic              lv_prev;
        logic              busy;
        logic [DATA_W-1:0] result;
    } flag_state_t;
endpackage

// File: rtl/irq_wake_sync.sv
module irq_wake_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{d}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irq_wake_chgdet.sv
module irq_wake_chgdet #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep,
    input  logic [W-1:0] port_s,
    output logic         change
);
    typedef struct packed {
        logic [W-1:0] snap;
        logic         sleep_q;
    } chg_state_t;

    chg_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.sleep_q = sleep;
        if (sleep && !st_q.sleep_q) st_d.snap = port_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign change = st_q.sleep_q && (port_s != st_q.snap);

    // R9
    no_change_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> !change);
endmodule

// File: rtl/irq_wake_flags.sv
module irq_wake_flags
    import irq_wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              lv_state,
    input  logic              wr_status,
    input  logic              wr_lvif,
    input  logic              wr_adif,
    input  logic [2:0]        wr_en,
    output flag_state_t       st
);
    flag_state_t st_d, st_q;
    logic lv_fall;

    always_comb begin
        st_d         = st_q;
        lv_fall      = st_q.lv_prev && !lv_state;
        st_d.lv_prev = lv_state;

        if (wr_status) begin
            if (!wr_lvif) st_d.lv_if = 1'b0;
            if (!wr_adif) st_d.ad_if = 1'b0;
            st_d.ad_wk = wr_en[2];
            st_d.pc_wk = wr_en[1];
            st_d.lv_wk = wr_en[0];
        end

        if (lv_fall) st_d.lv_if = 1'b1;

        if (conv_start) st_d.busy = 1'b1;
        if (conv_done) begin
            st_d.busy   = 1'b0;
            st_d.ad_if  = 1'b1;
            st_d.result = conv_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.lv_prev <= lv_state;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    // R1
    adif_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> st_q.ad_if && !st_q.busy && st_q.result == $past(conv_data));
    // R5
    adif_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_done && !st_q.ad_if) |=> !st_q.ad_if);
    // R5
    lvif_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lv_fall && !st_q.lv_if) |=> !st_q.lv_if);
    // R4
    lvif_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lv_prev && !lv_state) |=> st_q.lv_if);
    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !conv_done) |=> st_q.busy);
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
    import irq_wake_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              conv_busy,
    input  logic              lvd_en,
    input  logic              lvd_level,
    input  logic [PORT_W-1:0] port_in,
    input  logic              sleep,
    output logic              wake_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic              wake;
    } top_state_t;

    top_state_t  ts_d, ts_q;
    flag_state_t fl;
    logic              lv_s, lv_state, port_chg, wake_src, wr_status;
    logic [PORT_W-1:0] port_s;
    logic [DATA_W-1:0] status;

    irq_wake_sync #(.W(1), .STAGES(SYNC_LEN)) u_lv_sync (
        .clk(clk), .rst_n(rst_n), .d(lvd_level), .q(lv_s));

    irq_wake_sync #(.W(PORT_W), .STAGES(SYNC_LEN)) u_port_sync (
        .clk(clk), .rst_n(rst_n), .d(port_in), .q(port_s));

    assign lv_state = lvd_en ? lv_s : 1'b1;

    irq_wake_chgdet #(.W(PORT_W)) u_chg (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .port_s(port_s), .change(port_chg));

    assign wr_status = cpu_wr && (cpu_addr == ADDR_STATUS);

    irq_wake_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data),
        .lv_state(lv_state),
        .wr_status(wr_status),
        .wr_lvif(cpu_wdata[BIT_LVIF]), .wr_adif(cpu_wdata[BIT_ADIF]),
        .wr_en({cpu_wdata[BIT_ADWK], cpu_wdata[BIT_PCWK], cpu_wdata[BIT_LVWK]}),
        .st(fl));

    always_comb begin
        status           = '0;
        status[BIT_LVST] = lv_state;
        status[BIT_LVIF] = fl.lv_if;
        status[BIT_ADIF] = fl.ad_if;
        status[BIT_ADWK] = fl.ad_wk;
        status[BIT_PCWK] = fl.pc_wk;
        status[BIT_LVWK] = fl.lv_wk;
    end

    assign wake_src = (fl.ad_if && fl.ad_wk) || (port_chg && fl.pc_wk) ||
                      (fl.lv_if && fl.lv_wk);

    always_comb begin
        ts_d      = ts_q;
        ts_d.wake = sleep && (ts_q.wake || wake_src);
        if (cpu_wr && cpu_addr == ADDR_MASK) ts_d.mask = cpu_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q.mask <= MASK_RESET;
            ts_q.wake <= 1'b0;
        end else begin
            ts_q <= ts_d;
        end
    end

    always_comb begin
        case (cpu_addr)
            ADDR_STATUS: cpu_rdata = status & ts_q.mask;
            ADDR_MASK:   cpu_rdata = ts_q.mask;
            ADDR_RESULT: cpu_rdata = fl.result;
            default:     cpu_rdata = '0;
        endcase
    end

    assign wake_req  = ts_q.wake;
    assign conv_busy = fl.busy;

    // R7
    read_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == ADDR_STATUS) |-> (cpu_rdata & ~ts_q.mask) == '0);
    // R10
    wake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> !wake_req);
    // R10
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && sleep) |=> wake_req);
    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] == 1'b0 && status[2] == 1'b0);
endmodule

// File: tb/irq_wake_ctrl_tb.sv
module irq_wake_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_start = 1'b0, conv_done = 1'b0;
    logic [7:0] conv_data = '0;
    logic       conv_busy;
    logic       lvd_en = 1'b1, lvd_level = 1'b1;
    logic [7:0] port_in = 8'h3C;
    logic       sleep = 1'b0;
    logic       wake_req;
    logic [1:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_wake_ctrl #(.PORT_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
        .conv_data(conv_data), .conv_busy(conv_busy), .lvd_en(lvd_en),
        .lvd_level(lvd_level), .port_in(port_in), .sleep(sleep), .wake_req(wake_req),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata));

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        cpu_addr = a;
        #0.5;
        v = cpu_rdata;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] v);
        cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1;
        tick();
        cpu_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk("R11 status after reset", v, 8'h80);
        rd(2'd1, v); chk("R7 mask reset", v, 8'hFF);
        rd(2'd2, v); chk("R11 result reset", v, 8'h00);
        rd(2'd3, v); chk("R7 addr3 zero", v, 8'h00);
        chk("R11 busy reset", {7'd0, conv_busy}, 8'h00);
        chk("R11 wake reset", {7'd0, wake_req}, 8'h00);
    endtask

    task automatic t_conv();
        logic [7:0] v;
        conv_start = 1'b1; tick(); conv_start = 1'b0;
        chk("R2 busy set", {7'd0, conv_busy}, 8'h01);
        conv_data = 8'hA5; conv_done = 1'b1; tick(); conv_done = 1'b0;
        chk("R1 busy cleared", {7'd0, conv_busy}, 8'h00);
        rd(2'd2, v); chk("R1 result", v, 8'hA5);
        rd(2'd0, v); chk("R1 flag bit5", v, 8'hA0);
        conv_start = 1'b1; conv_done = 1'b1; conv_data = 8'h5A; tick();
        conv_start = 1'b0; conv_done = 1'b0;
        chk("R2 done beats start", {7'd0, conv_busy}, 8'h00);
        rd(2'd2, v); chk("R1 result second", v, 8'h5A);
    endtask

    task automatic t_clear_only();
        logic [7:0] v;
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk("R5 write ones keeps flag, R8 enables", v, 8'hAB);
        wr(2'd0, 8'h0B);
        rd(2'd0, v); chk("R5 clear bit5", v, 8'h8B);
        wr(2'd0, 8'h20);
        rd(2'd0, v); chk("R5 write one does not set", v, 8'h80);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        cpu_addr = 2'd0; cpu_wdata = 8'h00; cpu_wr = 1'b1; conv_done = 1'b1; conv_data = 8'h11;
        tick();
        cpu_wr = 1'b0; conv_done = 1'b0;
        rd(2'd0, v); chk("R6 hw set wins", v, 8'hA0);
        wr(2'd1, 8'h20);
        rd(2'd0, v); chk("R7 masked read", v, 8'h20);
        rd(2'd1, v); chk("R7 mask readback", v, 8'h20);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R5 cleared", v, 8'h80);
    endtask

    task automatic t_lvd();
        logic [7:0] v;
        lvd_level = 1'b0;
        tick(); rd(2'd0, v); chk("R3 state after 1 edge", v, 8'h80);
        tick(); rd(2'd0, v); chk("R3 state low after 2 edges", v, 8'h00);
        tick(); rd(2'd0, v); chk("R4 flag after fall", v, 8'h40);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R5 clear bit6", v, 8'h00);
        lvd_en = 1'b0;
        rd(2'd0, v); chk("R3 disabled reads 1", v, 8'h80);
        lvd_level = 1'b1;
        tick(3);
        lvd_en = 1'b1;
        tick(2);
        rd(2'd0, v); chk("R4 no flag on rise", v, 8'h80);
    endtask

    task automatic t_port_wake();
        wr(2'd0, 8'h02);
        sleep = 1'b1; tick(3);
        chk("R10 no wake without change", {7'd0, wake_req}, 8'h00);
        port_in = 8'h3D;
        tick(2); chk("R9 wake not before sync", {7'd0, wake_req}, 8'h00);
        tick();  chk("R9 R10 port change wakes", {7'd0, wake_req}, 8'h01);
        port_in = 8'h3C;
        tick(3); chk("R10 wake held", {7'd0, wake_req}, 8'h01);
        sleep = 1'b0; tick();
        chk("R10 wake drops on exit", {7'd0, wake_req}, 8'h00);
        wr(2'd0, 8'h00);
        sleep = 1'b1; tick(2);
        port_in = 8'h00; tick(5);
        chk("R10 port wake disabled", {7'd0, wake_req}, 8'h00);
        sleep = 1'b0; tick();
    endtask

    task automatic t_adc_wake();
        wr(2'd0, 8'h08);
        sleep = 1'b1; tick();
        conv_done = 1'b1; conv_data = 8'h77; tick(); conv_done = 1'b0;
        chk("R10 adc wake one edge later", {7'd0, wake_req}, 8'h00);
        tick(); chk("R10 adc wake", {7'd0, wake_req}, 8'h01);
        sleep = 1'b0; tick();
        wr(2'd0, 8'h00);
    endtask

    task automatic t_lvd_wake();
        logic [7:0] v;
        wr(2'd0, 8'h01);
        sleep = 1'b1; tick();
        lvd_level = 1'b0;
        tick(3); chk("R10 lvd wake not yet", {7'd0, wake_req}, 8'h00);
        tick();  chk("R10 lvd wake", {7'd0, wake_req}, 8'h01);
        sleep = 1'b0; tick();
        lvd_level = 1'b1; tick(3);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R8 enables cleared", v, 8'h80);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_conv();
        t_clear_only();
        t_set_wins();
        t_lvd();
        t_port_wake();
        t_adc_wake();
        t_lvd_wake();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %h expected %h", 8'h00, 8'h01);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule